// File: doc/BRIEF.md
# Reference Clock Failover Selector

This block chooses the timing reference for a TDM system from five candidates. Four of them are external clocks: a primary main, a primary fallback, a secondary main and a secondary fallback. The fifth is a local free-running oscillator. Each external clock has its own activity monitor. The monitor samples the clock through a two-flop synchronizer and counts rising edges in fixed windows of local-clock cycles, and from that it declares the clock lost or healthy.

A small selection stage walks the priority chain and registers its decision. It drives a one-hot select, a 3-bit source index, a one-cycle switch pulse and an alarm. Two configuration bits, loaded through a write strobe and cleared by reset, control the behaviour. One lets the selector fail forward away from a lost source. The other lets it climb back to a better source automatically. When automatic recovery is off, a manual revert pulse moves the selection back instead. The block makes the select decision only. Muxing the clock and switching it without glitches happen outside it.

Top module: `refclk_failover_sel`

## Requirements
- R1: `sel_onehot` always has exactly one bit set, and that bit is bit `sel_idx`. Index encoding: 0 primary main, 1 primary fallback, 2 secondary main, 3 secondary fallback, 4 local oscillator.
- R2: While the local oscillator (index 4) is selected and any external clock is healthy, the next selection is the healthy external clock with the lowest index. This move needs no enable.
- R3: When all four `ref_ok` bits are 0, index 4 is selected on the next clock, whatever the configuration.
- R4: With fallback disabled, a selected external clock that has been lost stays selected (if another clock is healthy), and `lost_alarm` is 1.
- R5: With fallback enabled, a selected external clock that has been lost is replaced on the next clock by the lowest-index healthy clock, and `lost_alarm` is 0.
- R6: With auto-recover enabled, a selected healthy clock is replaced on the next clock by any healthy clock of lower index.
- R7: With auto-recover disabled, a selected healthy clock stays selected even when a lower-index clock is healthy. One cycle of `revert_req` then moves the selection to the lowest-index healthy clock.
- R8: After reset both enables are 0. A cycle with `cfg_we` high loads `cfg_fallback` and `cfg_autorec`.
- R9: `switch_pulse` is high for exactly the one cycle in which `sel_idx` takes a new value, and at no other time.
- R10: `ref_ok[i]` falls at the end of a window of `win_cycles` local cycles that saw no rising edge on `ref_in[i]`. It rises only after `good_windows` consecutive windows that each saw an edge.
- R11: During and right after reset, `sel_idx`=4, `sel_onehot`=5'b10000, `ref_ok`=0, and `switch_pulse` and `lost_alarm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 4 | Asynchronous external reference clocks, index 0..3 |
| win_cycles | input | WIN_W | Monitor window length in local cycles |
| good_windows | input | GOOD_W | Consecutive good windows needed to declare a clock healthy |
| cfg_we | input | 1 | Load strobe for the two enable bits |
| cfg_fallback | input | 1 | Fallback enable value to load |
| cfg_autorec | input | 1 | Auto-recover enable value to load |
| revert_req | input | 1 | One-cycle manual request to return to the best healthy clock |
| sel_onehot | output | 5 | Registered one-hot select |
| sel_idx | output | 3 | Registered selected source index |
| switch_pulse | output | 1 | One-cycle pulse on each change of selection |
| lost_alarm | output | 1 | Selected external clock is lost and is being held |
| ref_ok | output | 4 | Health flags from the activity monitors |

## Verification
A change on `ref_in` reaches `ref_ok` only at a window boundary, after two synchronizer stages and one edge-detect stage. A loss therefore shows within two windows, and a recovery within `good_windows`+1 windows. The bench waits well past these bounds, 100 and 160 cycles with a 16-cycle window, before it compares `ref_ok`. The selection, pulse and alarm follow one cycle after a change in `ref_ok`, a configuration write or a revert pulse, and the bench samples them a few cycles later on the falling edge. Loss stimulus and recovery stimulus are applied in separate phases, so the bench model can step the expected selection through each intermediate health state.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int N_EXT     = 4;
  localparam int N_SRC     = N_EXT + 1;
  localparam int IDX_W     = $clog2(N_SRC);
  localparam int LOCAL_IDX = N_EXT;
  typedef logic [IDX_W-1:0] src_idx_t;
  typedef logic [N_EXT-1:0] ext_mask_t;
endpackage

// File: rtl/refclk_sync2.sv
module refclk_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta_q, stab_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end
  assign q = stab_q;
endmodule

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon #(
  parameter int WIN_W  = 8,
  parameter int GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_async,
  input  logic [WIN_W-1:0]  win_cycles,
  input  logic [GOOD_W-1:0] good_windows,
  output logic              healthy
);
  logic ref_s, ref_d, rise;
  logic [WIN_W-1:0]  win_cnt;
  logic [GOOD_W-1:0] good_cnt;
  logic              seen_q;
  logic              win_end;
  logic [WIN_W-1:0]  win_last;
  logic [GOOD_W-1:0] good_need;

  refclk_sync2 u_sync (.clk(clk), .rst(rst), .d(ref_async), .q(ref_s));

  always_ff @(posedge clk) begin
    if (rst) ref_d <= 1'b0;
    else     ref_d <= ref_s;
  end
  assign rise = ref_s & ~ref_d;

  // a zero setting is treated as one
  assign win_last  = (win_cycles == '0) ? '0 : win_cycles - 1'b1;
  assign good_need = (good_windows == '0) ? GOOD_W'(1) : good_windows;
  assign win_end   = (win_cnt == win_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      good_cnt <= '0;
      seen_q   <= 1'b0;
      healthy  <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      seen_q  <= 1'b0;
      if (seen_q || rise) begin
        if (good_cnt + 1'b1 >= good_need) begin
          healthy  <= 1'b1;
          good_cnt <= good_need;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end else begin
        healthy  <= 1'b0;
        good_cnt <= '0;
      end
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (rise) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/refclk_pick.sv
module refclk_pick
  import refclk_pkg::*;
(
  input  src_idx_t  cur,
  input  ext_mask_t ok,
  input  logic      fb_en,
  input  logic      ar_en,
  input  logic      revert,
  output src_idx_t  nxt,
  output logic      alarm
);
  src_idx_t best;
  logic     cur_ok;

  always_comb begin
    best = src_idx_t'(LOCAL_IDX);
    for (int i = N_EXT - 1; i >= 0; i--) begin
      if (ok[i]) best = src_idx_t'(i);
    end
  end

  assign cur_ok = (cur != src_idx_t'(LOCAL_IDX)) && ok[cur[IDX_W-2:0]];

  always_comb begin
    if (ok == '0)                            nxt = src_idx_t'(LOCAL_IDX);
    else if (cur == src_idx_t'(LOCAL_IDX))   nxt = best;
    else if (!cur_ok)                        nxt = fb_en ? best : cur;
    else if ((best < cur) && (ar_en || revert)) nxt = best;
    else                                     nxt = cur;
    alarm = (nxt != src_idx_t'(LOCAL_IDX)) && !ok[nxt[IDX_W-2:0]];
  end
endmodule

// File: rtl/refclk_failover_sel.sv
module refclk_failover_sel
  import refclk_pkg::*;
#(
  parameter int WIN_W  = 8,
  parameter int GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ref_in,
  input  logic [WIN_W-1:0]  win_cycles,
  input  logic [GOOD_W-1:0] good_windows,
  input  logic              cfg_we,
  input  logic              cfg_fallback,
  input  logic              cfg_autorec,
  input  logic              revert_req,
  output logic [4:0]        sel_onehot,
  output logic [2:0]        sel_idx,
  output logic              switch_pulse,
  output logic              lost_alarm,
  output logic [3:0]        ref_ok
);
  logic     fb_q, ar_q;
  src_idx_t sel_q, sel_nxt;
  logic     alarm_nxt;

  for (genvar g = 0; g < N_EXT; g++) begin : g_mon
    refclk_activity_mon #(.WIN_W(WIN_W), .GOOD_W(GOOD_W)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .ref_async    (ref_in[g]),
      .win_cycles   (win_cycles),
      .good_windows (good_windows),
      .healthy      (ref_ok[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q <= 1'b0;
      ar_q <= 1'b0;
    end else if (cfg_we) begin
      fb_q <= cfg_fallback;
      ar_q <= cfg_autorec;
    end
  end

  refclk_pick u_pick (
    .cur    (sel_q),
    .ok     (ref_ok),
    .fb_en  (fb_q),
    .ar_en  (ar_q),
    .revert (revert_req),
    .nxt    (sel_nxt),
    .alarm  (alarm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q        <= src_idx_t'(LOCAL_IDX);
      sel_onehot   <= 5'(1) << LOCAL_IDX;
      switch_pulse <= 1'b0;
      lost_alarm   <= 1'b0;
    end else begin
      sel_q        <= sel_nxt;
      sel_onehot   <= 5'(1) << sel_nxt;
      switch_pulse <= (sel_nxt != sel_q);
      lost_alarm   <= alarm_nxt;
    end
  end

  assign sel_idx = sel_q;
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ref_ok,
  input logic [4:0] sel_onehot,
  input logic [2:0] sel_idx,
  input logic       switch_pulse,
  input logic       lost_alarm,
  input logic       revert_req,
  input logic       fb_q,
  input logic       ar_q
);
  logic on_ext, cur_ok, better;
  assign on_ext = (sel_idx < 3'd4);
  assign cur_ok = on_ext && ref_ok[sel_idx[1:0]];
  assign better = (sel_idx == 3'd1 && ref_ok[0]) ||
                  (sel_idx == 3'd2 && |ref_ok[1:0]) ||
                  (sel_idx == 3'd3 && |ref_ok[2:0]);

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel_onehot) && sel_onehot[sel_idx]);
  p_leave_local_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_idx == 3'd4 && ref_ok != 4'd0) |=> sel_idx != 3'd4);
  p_all_lost_r3: assert property (@(posedge clk) disable iff (rst)
    (ref_ok == 4'd0) |=> sel_idx == 3'd4);
  p_hold_lost_r4: assert property (@(posedge clk) disable iff (rst)
    (!fb_q && on_ext && !cur_ok && ref_ok != 4'd0) |=> ($stable(sel_idx) && lost_alarm));
  p_fail_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (fb_q && on_ext && !cur_ok && ref_ok != 4'd0) |=> (sel_idx != $past(sel_idx) && !lost_alarm));
  p_autorec_r6: assert property (@(posedge clk) disable iff (rst)
    (ar_q && cur_ok && better) |=> sel_idx < $past(sel_idx));
  p_stay_r7: assert property (@(posedge clk) disable iff (rst)
    (!ar_q && !revert_req && cur_ok) |=> $stable(sel_idx));
  p_cfg_reset_r8: assert property (@(posedge clk)
    $fell(rst) |-> (!fb_q && !ar_q));
  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_idx != $past(sel_idx)) |-> switch_pulse);
  p_pulse_only_change_r9: assert property (@(posedge clk) disable iff (rst)
    switch_pulse |-> (sel_idx != $past(sel_idx)));
endmodule

bind refclk_failover_sel refclk_failover_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ref_ok       (ref_ok),
  .sel_onehot   (sel_onehot),
  .sel_idx      (sel_idx),
  .switch_pulse (switch_pulse),
  .lost_alarm   (lost_alarm),
  .revert_req   (revert_req),
  .fb_q         (fb_q),
  .ar_q         (ar_q)
);

// File: tb/refclk_failover_sel_test.sv
module refclk_failover_sel_test;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;
  localparam int GOODN = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ref_in = 4'd0;
  logic [3:0] run_mask = 4'd0;
  logic       cfg_we = 1'b0, cfg_fallback = 1'b0, cfg_autorec = 1'b0;
  logic       revert_req = 1'b0;
  logic [4:0] sel_onehot;
  logic [2:0] sel_idx;
  logic       switch_pulse, lost_alarm;
  logic [3:0] ref_ok;

  int total = 0, bad = 0, pulses = 0, phase = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  refclk_failover_sel #(.WIN_W(8), .GOOD_W(4)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in),
    .win_cycles(8'(WIN)), .good_windows(4'(GOODN)),
    .cfg_we(cfg_we), .cfg_fallback(cfg_fallback), .cfg_autorec(cfg_autorec),
    .revert_req(revert_req), .sel_onehot(sel_onehot), .sel_idx(sel_idx),
    .switch_pulse(switch_pulse), .lost_alarm(lost_alarm), .ref_ok(ref_ok)
  );

  // reference clocks: period 8 local cycles, in phase, stopped ones held low
  always @(negedge clk) begin
    phase <= (phase + 1) % 4;
    if (phase == 3) ref_in <= (ref_in ^ 4'hF) & run_mask;
    else            ref_in <= ref_in & run_mask;
    if (!rst && switch_pulse) pulses <= pulses + 1;
  end

  function automatic int model_step(int cur, logic [3:0] ok, bit fb, bit ar, bit rev);
    int best = 4;
    for (int i = 3; i >= 0; i--) if (ok[i]) best = i;
    if (ok == 4'd0) return 4;
    if (cur == 4) return best;
    if (!ok[cur]) return fb ? best : cur;
    if (best < cur && (ar || rev)) return best;
    return cur;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(bit fb, bit ar);
    cfg_fallback = fb; cfg_autorec = ar; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_revert();
    revert_req = 1'b1;
    cyc(1);
    revert_req = 1'b0;
  endtask

  task automatic check_sel(string req, int exp);
    check(req, sel_idx, exp);
    check({req, " onehot"}, sel_onehot, 5'(1) << exp);
  endtask

  initial begin
    int cur, p0, exp_sw, nxt;
    bit fb, ar, rev;
    logic [3:0] mask, nmask;
    cyc(3);
    // R11 reset state
    check_sel("R11", 4);
    check("R11 ok", ref_ok, 0);
    check("R11 pulse", switch_pulse, 0);
    check("R11 alarm", lost_alarm, 0);
    rst = 1'b0;
    cyc(1);
    check_sel("R11 post", 4);

    // R10 + R2: all clocks start, leave local for index 0
    run_mask = 4'hF; cyc(150);
    check("R10 ok rise", ref_ok, 4'hF);
    check_sel("R2", 0);
    check("R9 pulses", pulses, 1);

    // R8 default fallback off, R4 hold with alarm
    run_mask = 4'hE; cyc(100);
    check("R10 ok fall", ref_ok, 4'hE);
    check_sel("R4 hold", 0);
    check("R4 alarm", lost_alarm, 1);
    check("R8 default", sel_idx, 0);

    // R5 enable fallback
    write_cfg(1, 0); cyc(4);
    check_sel("R5", 1);
    check("R5 alarm", lost_alarm, 0);

    // R7 stays after recovery until revert
    run_mask = 4'hF; cyc(160);
    check_sel("R7 stay", 1);
    pulse_revert(); cyc(3);
    check_sel("R7 revert", 0);

    // R3 all lost
    run_mask = 4'h0; cyc(100);
    check_sel("R3", 4);
    check("R3 alarm", lost_alarm, 0);

    // R6 auto-recover
    write_cfg(1, 1);
    run_mask = 4'h8; cyc(160);
    check_sel("R2 lowest", 3);
    run_mask = 4'hC; cyc(160);
    check_sel("R6", 2);

    cur = 2; fb = 1; ar = 1; mask = 4'hC;
    process::self().srandom(32'd1234);
    for (int it = 0; it < 30; it++) begin
      fb = 1'($urandom); ar = 1'($urandom); rev = 1'($urandom);
      nmask = 4'($urandom);
      p0 = pulses; exp_sw = 0;
      write_cfg(fb, ar); cyc(4);
      nxt = model_step(cur, mask, fb, ar, 0); exp_sw += (nxt != cur); cur = nxt;
      check_sel("R8 cfg write", cur);
      run_mask = mask & nmask; cyc(100);
      nxt = model_step(cur, mask & nmask, fb, ar, 0); exp_sw += (nxt != cur); cur = nxt;
      run_mask = nmask; cyc(160);
      nxt = model_step(cur, nmask, fb, ar, 0); exp_sw += (nxt != cur); cur = nxt;
      mask = nmask;
      check("R10 rand", ref_ok, mask);
      check_sel("R5 R6 rand", cur);
      check("R4 rand alarm", lost_alarm, (cur != 4 && !mask[cur]) ? 1 : 0);
      if (rev) begin
        pulse_revert(); cyc(3);
        nxt = model_step(cur, mask, fb, ar, 1); exp_sw += (nxt != cur); cur = nxt;
        check_sel("R7 rand revert", cur);
      end
      check("R9 rand pulses", pulses - p0, exp_sw);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule